// File: doc/BRIEF.md
# Call Progress Tone Cadence Classifier

This block tells which call progress tone is on a telephone line. Its only input is a one-bit tone envelope that an upstream detector has already produced. A millisecond time base is derived from the system clock. The envelope first passes through a glitch filter: a short dropout inside a tone is ignored, and so is a short burst inside silence. The block then times each on period and each off period of the filtered envelope and compares the repeating pattern against windows for dial tone, busy, re-order and ring-back. It reports the tone as a 3-bit status code on outputs that can be switched to high impedance.

A tone is declared in one of two ways: two consecutive on/off cycles fall in the same class, or a single on period lasts past the dial-tone timeout. When a tone is declared, a data-valid flag rises and stays high until a synchronous clear is applied or a newer declaration replaces the code. A count-busy flag shows that the filter has accepted an edge and no decision has been made yet. A controller uses the code to decide whether to go on dialling, wait or hang up.

Top module: `cadence_classifier`

## Requirements
- R1: After reset the internal code is 000 (no decision), data_valid is 0 and count_busy is 0.
- R2: While the tone is present, a dropout of 20 ms or less leaves the filtered envelope high. A tone with such dropouts still reaches the dial-tone timeout as if it were continuous.
- R3: While the line is silent, a burst of 20 ms or less is never accepted as an edge, so count_busy stays 0.
- R4: A level held for 40 ms is accepted as a real edge of the filtered envelope. The first edge accepted from idle raises count_busy.
- R5: When the filtered envelope stays high for 2000 ms, code 001 (dial tone) is declared with data_valid 1. Nothing is declared before that point.
- R6: Two consecutive cycles with on and off each between 375 and 625 ms declare code 011 (busy).
- R7: Two consecutive cycles with on and off each between 188 and 312 ms declare code 100 (re-order).
- R8: Two consecutive cycles with on between 800 ms and 2500 ms and off between 2500 and 5000 ms declare code 010 (ring-back). An on period that reaches 2000 ms is declared dial tone first.
- R9: Two consecutive cycles that match none of the windows declare code 111 (unrecognized).
- R10: A cycle whose class differs from the previous cycle starts a new count, so no declaration is made. While data_valid is low the code only changes when it is cleared.
- R11: status_code carries the code while tri_en is 1 and is high impedance while tri_en is 0.
- R12: A clear pulse returns the filter, the duration timers, the match count, data_valid, count_busy and the code to idle by the next clock.
- R13: count_busy is high from the first accepted edge until data_valid asserts, and is never high together with data_valid.
- R14: The duration timers stop at 8191 ms. An off period of 8442 ms after a 250 ms on period is unrecognized; it does not wrap around into the re-order window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear back to idle |
| tone_env | input | 1 | Raw tone envelope from the detector |
| tri_en | input | 1 | Drive enable for status_code |
| status_code | output | 3 | Tone code, high impedance when tri_en is 0 |
| data_valid | output | 1 | A tone has been declared |
| count_busy | output | 1 | Edges seen, decision pending |

## Verification
The hardest case to reach is the wrap-around one: an off period long enough to overflow the 13-bit timer, which must still not be read as a short off time. The bench reaches it with a directed sequence. It first sends one re-order cycle. It then sends a 250 ms tone followed by an 8442 ms silence, which a wrapping timer would measure as about 250 ms, and checks that nothing is declared. Further stimulus comes from random on/off cadences kept clear of the window edges, and their expected codes are computed by a bench function from the requirement windows.

// File: rtl/cadence_pkg.sv
// Shared tone codes for the cadence classifier.
// Assumes a 3-bit status field read by an external controller.
package cadence_pkg;
    typedef enum logic [2:0] {
        TONE_NONE    = 3'b000,
        TONE_DIAL    = 3'b001,
        TONE_RING    = 3'b010,
        TONE_BUSY    = 3'b011,
        TONE_REORDER = 3'b100,
        TONE_UNKNOWN = 3'b111
    } tone_e;
endpackage

// File: rtl/ms_tick_gen.sv
// Divides the system clock down to a one-cycle pulse every millisecond.
// Assumes DIV >= 2 clocks per millisecond.
module ms_tick_gen #(
    parameter int DIV = 3580
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Free-running divider that emits a tick on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/env_filter.sv
// Glitch filter for the tone envelope. A level must differ from the held
// state on ACCEPT_MS consecutive ticks before it is taken. Assumes the raw
// input is asynchronous, so it is synchronized first.
module env_filter #(
    parameter int ACCEPT_MS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic raw,
    output logic env,
    output logic rise,
    output logic fall
);
    localparam int AW = $clog2(ACCEPT_MS + 1);

    logic [1:0]    sync_q;
    logic [AW-1:0] run_q;

    // Two-flop synchronizer for the raw envelope.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw};
    end

    // Count disagreeing ticks; flip state and pulse an edge once enough pile up.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            env   <= 1'b0;
            run_q <= '0;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (tick) begin
                if (sync_q[1] != env) begin
                    if (run_q == AW'(ACCEPT_MS - 1)) begin
                        env   <= sync_q[1];
                        rise  <= sync_q[1];
                        fall  <= ~sync_q[1];
                        run_q <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/cadence_timer.sv
// Times on and off periods of the filtered envelope in milliseconds.
// A cycle is reported at each rising edge that follows a completed on period.
// Counters saturate at all-ones. Flags the dial timeout during one on period.
module cadence_timer #(
    parameter int MS_W    = 13,
    parameter int DIAL_MS = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic            env,
    input  logic            rise,
    input  logic            fall,
    output logic [MS_W-1:0] on_len,
    output logic [MS_W-1:0] off_len,
    output logic            cycle_done,
    output logic            dial_hit
);
    localparam logic [MS_W-1:0] SAT = '1;

    logic [MS_W-1:0] on_ms;
    logic [MS_W-1:0] off_ms;
    logic            have_on;

    // Period counters, captured lengths and cycle / timeout pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            on_ms      <= '0;
            off_ms     <= '0;
            on_len     <= '0;
            off_len    <= '0;
            have_on    <= 1'b0;
            cycle_done <= 1'b0;
            dial_hit   <= 1'b0;
        end else begin
            cycle_done <= 1'b0;
            dial_hit   <= 1'b0;
            if (fall) begin
                on_len  <= on_ms;
                on_ms   <= '0;
                off_ms  <= '0;
                have_on <= 1'b1;
            end else if (rise) begin
                cycle_done <= have_on;
                off_len    <= off_ms;
                on_ms      <= '0;
                off_ms     <= '0;
            end else if (tick) begin
                if (env) begin
                    if (on_ms != SAT) on_ms <= on_ms + 1'b1;
                    if (on_ms == MS_W'(DIAL_MS - 1)) dial_hit <= 1'b1;
                end else if (off_ms != SAT) begin
                    off_ms <= off_ms + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cadence_judge.sv
// Sorts each completed cycle into a tone class and declares a tone once
// MATCH_N consecutive cycles agree, or at once on the dial timeout.
// Owns the status code, data-valid and count-busy flags.
module cadence_judge
    import cadence_pkg::*;
#(
    parameter int MS_W        = 13,
    parameter int MATCH_N     = 2,
    parameter int BUSY_LO     = 375,
    parameter int BUSY_HI     = 625,
    parameter int REO_LO      = 188,
    parameter int REO_HI      = 312,
    parameter int RING_ON_LO  = 800,
    parameter int RING_ON_HI  = 2500,
    parameter int RING_OFF_LO = 2500,
    parameter int RING_OFF_HI = 5000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            edge_any,
    input  logic            cycle_done,
    input  logic            dial_hit,
    input  logic [MS_W-1:0] on_len,
    input  logic [MS_W-1:0] off_len,
    output tone_e           code_q,
    output logic            valid_q,
    output logic            busy_q
);
    localparam int RW = $clog2(MATCH_N + 1);

    tone_e         cls, prev_q, nxt_prev, decl_code;
    logic [RW-1:0] run_q, nxt_run;
    logic          decl;

    function automatic logic in_band(logic [MS_W-1:0] v, int lo, int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

    // Class of the cycle just completed.
    always_comb begin
        if (in_band(on_len, BUSY_LO, BUSY_HI) && in_band(off_len, BUSY_LO, BUSY_HI))
            cls = TONE_BUSY;
        else if (in_band(on_len, REO_LO, REO_HI) && in_band(off_len, REO_LO, REO_HI))
            cls = TONE_REORDER;
        else if (in_band(on_len, RING_ON_LO, RING_ON_HI) &&
                 in_band(off_len, RING_OFF_LO, RING_OFF_HI))
            cls = TONE_RING;
        else
            cls = TONE_UNKNOWN;
    end

    // Match counting and declaration decision.
    always_comb begin
        decl      = 1'b0;
        decl_code = code_q;
        nxt_run   = run_q;
        nxt_prev  = prev_q;
        if (cycle_done) begin
            if (run_q != '0 && cls == prev_q) begin
                nxt_run = run_q + 1'b1;
            end else begin
                nxt_run  = RW'(1);
                nxt_prev = cls;
            end
            if (nxt_run == RW'(MATCH_N)) begin
                decl      = 1'b1;
                decl_code = cls;
                nxt_run   = '0;
            end
        end
        if (dial_hit) begin
            decl      = 1'b1;
            decl_code = TONE_DIAL;
            nxt_run   = '0;
        end
    end

    // Decision state registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code_q  <= TONE_NONE;
            prev_q  <= TONE_NONE;
            run_q   <= '0;
            valid_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            run_q  <= nxt_run;
            prev_q <= nxt_prev;
            if (decl) begin
                code_q  <= decl_code;
                valid_q <= 1'b1;
                busy_q  <= 1'b0;
            end else if (edge_any && !valid_q) begin
                busy_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cadence_classifier.sv
// Top of the call progress cadence classifier: time base, envelope filter,
// period timer and decision logic. Assumes the envelope input is already a
// clean-ish logic level from an analog detector.
module cadence_classifier
    import cadence_pkg::*;
#(
    parameter int TICK_DIV    = 3580,
    parameter int ACCEPT_MS   = 30,
    parameter int MS_W        = 13,
    parameter int DIAL_MS     = 2000,
    parameter int MATCH_N     = 2,
    parameter int BUSY_LO     = 375,
    parameter int BUSY_HI     = 625,
    parameter int REO_LO      = 188,
    parameter int REO_HI      = 312,
    parameter int RING_ON_LO  = 800,
    parameter int RING_ON_HI  = 2500,
    parameter int RING_OFF_LO = 2500,
    parameter int RING_OFF_HI = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       tone_env,
    input  logic       tri_en,
    output logic [2:0] status_code,
    output logic       data_valid,
    output logic       count_busy
);
    logic            tick;
    logic            deb_env, deb_rise, deb_fall;
    logic [MS_W-1:0] on_len, off_len;
    logic            cycle_done, dial_hit;
    tone_e           code_q;

    ms_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    env_filter #(.ACCEPT_MS(ACCEPT_MS)) i_filter (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .raw(tone_env),
        .env(deb_env), .rise(deb_rise), .fall(deb_fall)
    );

    cadence_timer #(.MS_W(MS_W), .DIAL_MS(DIAL_MS)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .env(deb_env),
        .rise(deb_rise), .fall(deb_fall), .on_len(on_len), .off_len(off_len),
        .cycle_done(cycle_done), .dial_hit(dial_hit)
    );

    cadence_judge #(
        .MS_W(MS_W), .MATCH_N(MATCH_N),
        .BUSY_LO(BUSY_LO), .BUSY_HI(BUSY_HI), .REO_LO(REO_LO), .REO_HI(REO_HI),
        .RING_ON_LO(RING_ON_LO), .RING_ON_HI(RING_ON_HI),
        .RING_OFF_LO(RING_OFF_LO), .RING_OFF_HI(RING_OFF_HI)
    ) i_judge (
        .clk(clk), .rst_n(rst_n), .clear(clear), .edge_any(deb_rise | deb_fall),
        .cycle_done(cycle_done), .dial_hit(dial_hit), .on_len(on_len),
        .off_len(off_len), .code_q(code_q), .valid_q(data_valid),
        .busy_q(count_busy)
    );

    // Status bits are driven only while enabled.
    assign status_code = tri_en ? code_q : 3'bzzz;
endmodule

// File: rtl/cadence_classifier_chk.sv
// Property checker for the cadence classifier, attached by bind.
module cadence_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clear,
    input logic       tick,
    input logic       deb_env,
    input logic [2:0] code_q,
    input logic       data_valid,
    input logic       count_busy
);
    // R12
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!data_valid && code_q == 3'b000 && !count_busy && !deb_env));

    // R13
    busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(count_busy && data_valid));

    // R5
    valid_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> code_q != 3'b000);

    // R2
    filter_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(deb_env) |-> ($past(tick) || $past(clear)));

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> (data_valid || $past(clear)));
endmodule

bind cadence_classifier cadence_classifier_chk i_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .deb_env(deb_env),
    .code_q(code_q), .data_valid(data_valid), .count_busy(count_busy)
);

// File: tb/test_cadence_classifier.sv
module test_cadence_classifier;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic env = 1'b0;
    logic tri_en = 1'b1;
    tri1 [2:0] code_w;
    logic dv, cb;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cadence_classifier #(.TICK_DIV(DIV)) i_cadence_classifier (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tone_env(env), .tri_en(tri_en),
        .status_code(code_w), .data_valid(dv), .count_busy(cb)
    );

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ms(int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
    endtask

    task automatic cyc(int on_t, int off_t);
        env = 1'b1; ms(on_t);
        env = 1'b0; ms(off_t);
    endtask

    // Expected tone code from the requirement windows (R6..R9).
    function automatic int exp_class(int on_t, int off_t);
        if (on_t >= 375 && on_t <= 625 && off_t >= 375 && off_t <= 625) return 3;
        if (on_t >= 188 && on_t <= 312 && off_t >= 188 && off_t <= 312) return 4;
        if (on_t >= 800 && on_t <= 2500 && off_t >= 2500 && off_t <= 5000) return 2;
        return 7;
    endfunction

    function automatic bit near_edge(int v);
        return (v > 180 && v < 196) || (v > 304 && v < 320) ||
               (v > 367 && v < 383) || (v > 617 && v < 633);
    endfunction

    task automatic finish_case();
        env = 1'b0; ms(60);
        do_clear();
        ms(5);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        ms(5);
        @(negedge clk) rst_n = 1'b1;
        ms(2);
        check_eq("R1 code", int'(code_w), 0);
        check_eq("R1 data_valid", int'(dv), 0);
        check_eq("R1 count_busy", int'(cb), 0);

        // R3: short bursts during silence are never accepted
        for (int i = 0; i < 5; i++) begin
            env = 1'b1; ms(20); env = 1'b0; ms(150);
        end
        check_eq("R3 busy after bursts", int'(cb), 0);

        // R4: 40 ms level is accepted
        env = 1'b1; ms(45);
        check_eq("R4 busy after 40ms", int'(cb), 1);
        finish_case();

        // R5/R2/R13: dial tone with short dropouts
        env = 1'b1; ms(100);
        check_eq("R13 busy pending", int'(cb), 1);
        for (int i = 0; i < 3; i++) begin
            ms(400); env = 1'b0; ms(20); env = 1'b1;
        end
        ms(500);
        check_eq("R5 no early decision", int'(dv), 0);
        ms(260);
        check_eq("R5 dial valid", int'(dv), 1);
        check_eq("R2 dial code through dropouts", int'(code_w), 1);
        check_eq("R13 busy low after decision", int'(cb), 0);

        // R11: tri-state release reads the bench pull-up
        @(negedge clk) tri_en = 1'b0;
        #1 check_eq("R11 released", int'(code_w), 7);
        @(negedge clk) tri_en = 1'b1;
        #1 check_eq("R11 driven", int'(code_w), 1);

        // R12: clear returns to idle
        env = 1'b0;
        do_clear();
        check_eq("R12 valid", int'(dv), 0);
        check_eq("R12 code", int'(code_w), 0);
        check_eq("R12 busy", int'(cb), 0);
        ms(60);
        do_clear();

        // R6: busy
        cyc(500, 500); cyc(500, 500);
        env = 1'b1; ms(60);
        check_eq("R6 valid", int'(dv), 1);
        check_eq("R6 busy code", int'(code_w), 3);
        finish_case();

        // R10 then R7: mismatch restarts the count
        cyc(500, 500); cyc(250, 250);
        env = 1'b1; ms(60);
        check_eq("R10 no decision on mismatch", int'(dv), 0);
        check_eq("R10 code unchanged", int'(code_w), 0);
        ms(190); env = 1'b0; ms(250);
        env = 1'b1; ms(60);
        check_eq("R7 reorder valid", int'(dv), 1);
        check_eq("R7 reorder code", int'(code_w), 4);
        finish_case();

        // R8: ring-back
        cyc(1000, 3000); cyc(1000, 3000);
        env = 1'b1; ms(60);
        check_eq("R8 ring code", int'(code_w), 2);
        finish_case();

        // R9: unrecognized cadence
        cyc(100, 100); cyc(100, 100);
        env = 1'b1; ms(60);
        check_eq("R9 unknown code", int'(code_w), 7);
        finish_case();

        // R14: long silence saturates instead of wrapping
        cyc(250, 250); cyc(250, 8442);
        env = 1'b1; ms(60);
        check_eq("R14 no wrap decision", int'(dv), 0);
        check_eq("R14 code", int'(code_w), 0);
        finish_case();

        // Random cadences checked against the window function
        for (int t = 0; t < 6; t++) begin
            int on_t, off_t, e;
            do on_t = 100 + int'($urandom_range(700)); while (near_edge(on_t));
            do off_t = 100 + int'($urandom_range(700)); while (near_edge(off_t));
            e = exp_class(on_t, off_t);
            cyc(on_t, off_t); cyc(on_t, off_t);
            env = 1'b1; ms(60);
            check_eq("R6-class random valid R9", int'(dv), 1);
            check_eq("R7 random code R8", int'(code_w), e);
            finish_case();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule